// File: doc/BRIEF.md
# Per-Thread Fetch Status Controller

This block decides, once per cycle and for every hardware thread of a multithreaded front end, what the thread's fetch status becomes next. It reads the feedback that later pipeline stages send upstream: block and release pulses from the four downstream stages (decode, rename, execute, commit), a squash from commit and a squash from decode, each with a redirect PC, a flag saying the reorder buffer is still flushing, and a global context-switch hold. The current status of each thread is an input, because the fetch engine owns the status register and also moves threads into and out of the cache-wait states. The block returns the next status, a changed flag, the PC to load on a redirect, and a request to drop an outstanding cache miss.

For each thread, the block keeps one sticky stall bit per downstream stage internally. These bits are updated before the stall test in the same cycle. It also keeps one stage-level activity flag that tells the clocking logic whether any active thread is in a state that can make progress. Threads that are not active are left untouched.

Top module: `fetch_status_ctrl`

## Requirements
- R1: Status codes are Running 0, Idle 1, Squashing 2, Blocked 3, TrapPending 4, QuiescePending 5, waiting for cache response 6, waiting for cache retry 7, cache access complete 8. Reset clears every stall bit and sets stage_active to 1.
- R2: Each thread has a sticky stall bit per downstream stage. A set pulse sets it and a clear pulse clears it, and the update is already visible to the stall test of the same cycle. A clear is only legal while the bit is set and its set pulse is low.
- R3: A thread is stalled when ctx_switch or any of its stall bits is high. If no higher rule fires, a stalled thread whose status is not 6 or 7 gets next status Blocked with changed high, even if it is already Blocked.
- R4: A commit squash has top priority. The next status is Squashing, changed is high, redirect_valid is high and redirect_pc equals the commit PC.
- R5: Without a commit squash, rob_squashing gives next status Squashing with changed high and no redirect.
- R6: A decode squash gives Squashing, changed and a redirect to the decode PC only when the current status is not Squashing. When the status is already Squashing it causes no redirect, and the lower rules decide.
- R7: A stalled thread in status 6 or 7 that sees no squash keeps its status, with changed low.
- R8: If no higher rule fires and the status is Blocked or Squashing, the next status is Running with changed high.
- R9: In every other case the next status equals the current one and changed is low.
- R10: drop_miss is high exactly when a commit squash, or an accepted decode squash, finds the thread in status 6.
- R11: For a thread with thread_active low, the next status equals the current one, changed, redirect_valid and drop_miss are low, and its stall bits keep their values.
- R12: stage_active updates at a clock edge only when some active thread reports changed. It then becomes the OR, over active threads, of the next status being Running, Squashing or 8. Otherwise it holds.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| thread_active | input | NT | Thread is scheduled and evaluated this cycle |
| ctx_switch | input | 1 | Global context-switch stall |
| stall_set | input | NT*4 | Set pulses, bit t*4+s; s = 0 decode, 1 rename, 2 execute, 3 commit |
| stall_clr | input | NT*4 | Clear pulses, same indexing |
| commit_squash | input | NT | Squash from commit |
| commit_pc | input | NT*PC_W | Commit redirect PC per thread |
| rob_squashing | input | NT | Reorder buffer still flushing |
| decode_squash | input | NT | Squash from decode |
| decode_pc | input | NT*PC_W | Decode redirect PC per thread |
| cur_status | input | NT*4 | Current status per thread |
| next_status | output | NT*4 | Next status per thread |
| status_changed | output | NT | A status rule fired |
| redirect_valid | output | NT | Load redirect_pc |
| redirect_pc | output | NT*PC_W | PC to load |
| drop_miss | output | NT | Discard the outstanding cache miss |
| stage_active | output | 1 | Stage-level activity flag |

## Verification
The hardest situations to reach are the ones where priorities collide. Examples are a decode squash arriving at a thread that is already Squashing while commit is quiet, and a stalled thread sitting in a cache-wait state while squashes come in. Because cur_status is a primary input, the stimulus places threads directly in any status, including the cache-wait codes. It then overlays weighted random squash, flush, stall and release pulses, with releases issued only for bits the bench model knows are set. Directed sequences also force the activity flag low and confirm that it holds while threads run without reporting a change.

// File: rtl/fsc_pkg.sv
package fsc_pkg;

    localparam int STAT_W = 4;
    localparam int NSTAGE = 4;

    typedef enum logic [STAT_W-1:0] {
        FS_RUN      = 4'd0,
        FS_IDLE     = 4'd1,
        FS_SQUASH   = 4'd2,
        FS_BLOCKED  = 4'd3,
        FS_TRAP     = 4'd4,
        FS_QUIESCE  = 4'd5,
        FS_IC_WAIT  = 4'd6,
        FS_IC_RETRY = 4'd7,
        FS_IC_DONE  = 4'd8
    } fstat_e;

    // Per-thread feedback reduced to the events the rules look at
    typedef struct packed {
        logic cmt_sq;
        logic rob_sq;
        logic dec_sq;
        logic stalled;
    } thr_ev_t;

    function automatic logic in_cache_wait(logic [STAT_W-1:0] s);
        return (s == FS_IC_WAIT) || (s == FS_IC_RETRY);
    endfunction

    function automatic logic is_live(logic [STAT_W-1:0] s);
        return (s == FS_RUN) || (s == FS_SQUASH) || (s == FS_IC_DONE);
    endfunction

endpackage

// File: rtl/fsc_stall_track.sv
// Sticky per-stage stall bits of one thread (R2). The next-state value is
// exported so that the stall test sees this cycle's pulses.
module fsc_stall_track #(
    parameter int NSTAGE = 4
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              en,
    input  logic [NSTAGE-1:0] set_i,
    input  logic [NSTAGE-1:0] clr_i,
    output logic [NSTAGE-1:0] bits_nxt
);
    logic [NSTAGE-1:0] bits_q;

    for (genvar s = 0; s < NSTAGE; s++) begin : g_stage
        always_comb begin
            bits_nxt[s] = bits_q[s];
            if (en) begin
                if (set_i[s])      bits_nxt[s] = 1'b1;
                else if (clr_i[s]) bits_nxt[s] = 1'b0;
            end
        end

        always_ff @(posedge clk) begin
            if (rst) bits_q[s] <= 1'b0;
            else     bits_q[s] <= bits_nxt[s];
        end
    end
endmodule

// File: rtl/fsc_thread_rules.sv
// Fixed-priority next-status decision for one thread (R3..R11).
module fsc_thread_rules
    import fsc_pkg::*;
#(
    parameter int PC_W = 32
) (
    input  logic              active,
    input  logic [STAT_W-1:0] cur,
    input  thr_ev_t           ev,
    input  logic [PC_W-1:0]   cmt_pc,
    input  logic [PC_W-1:0]   dec_pc,
    output logic [STAT_W-1:0] nxt,
    output logic              changed,
    output logic              redir_v,
    output logic [PC_W-1:0]   redir_pc,
    output logic              drop
);
    always_comb begin
        nxt      = cur;
        changed  = 1'b0;
        redir_v  = 1'b0;
        redir_pc = '0;
        drop     = 1'b0;
        if (active) begin
            if (ev.cmt_sq) begin
                // R4: commit redirect wins over everything
                nxt      = FS_SQUASH;
                changed  = 1'b1;
                redir_v  = 1'b1;
                redir_pc = cmt_pc;
                drop     = (cur == FS_IC_WAIT);
            end else if (ev.rob_sq) begin
                // R5
                nxt     = FS_SQUASH;
                changed = 1'b1;
            end else if (ev.dec_sq && (cur != FS_SQUASH)) begin
                // R6
                nxt      = FS_SQUASH;
                changed  = 1'b1;
                redir_v  = 1'b1;
                redir_pc = dec_pc;
                drop     = (cur == FS_IC_WAIT);
            end else if (ev.stalled && !in_cache_wait(cur)) begin
                // R3; cache-wait states are shielded (R7)
                nxt     = FS_BLOCKED;
                changed = 1'b1;
            end else if ((cur == FS_BLOCKED) || (cur == FS_SQUASH)) begin
                // R8
                nxt     = FS_RUN;
                changed = 1'b1;
            end
        end
    end
endmodule

// File: rtl/fsc_stage_activity.sv
// Stage-level activity flag (R12), refreshed only on a reported change.
module fsc_stage_activity #(
    parameter int NT = 4
) (
    input  logic          clk,
    input  logic          rst,
    input  logic [NT-1:0] active,
    input  logic [NT-1:0] changed,
    input  logic [NT-1:0] live,
    output logic          stage_active
);
    logic any_change;
    logic any_live;

    assign any_change = |(active & changed);
    assign any_live   = |(active & live);

    always_ff @(posedge clk) begin
        if (rst)             stage_active <= 1'b1;
        else if (any_change) stage_active <= any_live;
    end
endmodule

// File: rtl/fetch_status_ctrl.sv
module fetch_status_ctrl
    import fsc_pkg::*;
#(
    parameter int NT   = 4,
    parameter int PC_W = 32
) (
    input  logic                 clk,
    input  logic                 rst,
    input  logic [NT-1:0]        thread_active,
    input  logic                 ctx_switch,
    input  logic [NT*NSTAGE-1:0] stall_set,
    input  logic [NT*NSTAGE-1:0] stall_clr,
    input  logic [NT-1:0]        commit_squash,
    input  logic [NT*PC_W-1:0]   commit_pc,
    input  logic [NT-1:0]        rob_squashing,
    input  logic [NT-1:0]        decode_squash,
    input  logic [NT*PC_W-1:0]   decode_pc,
    input  logic [NT*STAT_W-1:0] cur_status,
    output logic [NT*STAT_W-1:0] next_status,
    output logic [NT-1:0]        status_changed,
    output logic [NT-1:0]        redirect_valid,
    output logic [NT*PC_W-1:0]   redirect_pc,
    output logic [NT-1:0]        drop_miss,
    output logic                 stage_active
);
    logic [NT-1:0] live;

    for (genvar t = 0; t < NT; t++) begin : g_thr
        logic [NSTAGE-1:0] bits_nxt;
        thr_ev_t           ev;

        fsc_stall_track #(.NSTAGE(NSTAGE)) u_stall (
            .clk      (clk),
            .rst      (rst),
            .en       (thread_active[t]),
            .set_i    (stall_set[t*NSTAGE +: NSTAGE]),
            .clr_i    (stall_clr[t*NSTAGE +: NSTAGE]),
            .bits_nxt (bits_nxt)
        );

        always_comb begin
            ev.cmt_sq  = commit_squash[t];
            ev.rob_sq  = rob_squashing[t];
            ev.dec_sq  = decode_squash[t];
            ev.stalled = ctx_switch | (|bits_nxt);
        end

        fsc_thread_rules #(.PC_W(PC_W)) u_rules (
            .active   (thread_active[t]),
            .cur      (cur_status[t*STAT_W +: STAT_W]),
            .ev       (ev),
            .cmt_pc   (commit_pc[t*PC_W +: PC_W]),
            .dec_pc   (decode_pc[t*PC_W +: PC_W]),
            .nxt      (next_status[t*STAT_W +: STAT_W]),
            .changed  (status_changed[t]),
            .redir_v  (redirect_valid[t]),
            .redir_pc (redirect_pc[t*PC_W +: PC_W]),
            .drop     (drop_miss[t])
        );

        assign live[t] = is_live(next_status[t*STAT_W +: STAT_W]);
    end

    fsc_stage_activity #(.NT(NT)) u_act (
        .clk          (clk),
        .rst          (rst),
        .active       (thread_active),
        .changed      (status_changed),
        .live         (live),
        .stage_active (stage_active)
    );
endmodule

// File: rtl/fsc_checker.sv
module fsc_checker #(
    parameter int NT   = 4,
    parameter int PC_W = 32
) (
    input logic               clk,
    input logic               rst,
    input logic [NT-1:0]      thread_active,
    input logic [NT*4-1:0]    stall_set,
    input logic [NT*4-1:0]    stall_clr,
    input logic [NT-1:0]      commit_squash,
    input logic [NT*PC_W-1:0] commit_pc,
    input logic [NT-1:0]      rob_squashing,
    input logic [NT-1:0]      decode_squash,
    input logic [NT*4-1:0]    cur_status,
    input logic [NT*4-1:0]    next_status,
    input logic [NT-1:0]      status_changed,
    input logic [NT-1:0]      redirect_valid,
    input logic [NT*PC_W-1:0] redirect_pc,
    input logic [NT-1:0]      drop_miss,
    input logic               stage_active
);
    for (genvar t = 0; t < NT; t++) begin : g_t
        for (genvar s = 0; s < 4; s++) begin : g_s
            assert_clear_legal_R2: assert property (@(posedge clk) disable iff (rst)
                stall_clr[t*4+s] |-> !stall_set[t*4+s]);
        end

        assert_commit_first_R4: assert property (@(posedge clk) disable iff (rst)
            (thread_active[t] && commit_squash[t]) |->
            (redirect_valid[t] && next_status[t*4 +: 4] == 4'd2 &&
             redirect_pc[t*PC_W +: PC_W] == commit_pc[t*PC_W +: PC_W]));

        assert_cache_wait_kept_R7: assert property (@(posedge clk) disable iff (rst)
            (thread_active[t] && !commit_squash[t] && !rob_squashing[t] &&
             !decode_squash[t] &&
             (cur_status[t*4 +: 4] == 4'd6 || cur_status[t*4 +: 4] == 4'd7)) |->
            (!status_changed[t] && next_status[t*4 +: 4] == cur_status[t*4 +: 4]));

        assert_quiet_same_R9: assert property (@(posedge clk) disable iff (rst)
            !status_changed[t] |-> (next_status[t*4 +: 4] == cur_status[t*4 +: 4]));

        assert_drop_only_on_wait_R10: assert property (@(posedge clk) disable iff (rst)
            drop_miss[t] |-> (cur_status[t*4 +: 4] == 4'd6 && redirect_valid[t]));

        assert_inactive_inert_R11: assert property (@(posedge clk) disable iff (rst)
            !thread_active[t] |-> (!status_changed[t] && !redirect_valid[t] && !drop_miss[t]));
    end

    assert_activity_hold_R12: assert property (@(posedge clk) disable iff (rst)
        ((thread_active & status_changed) == '0) |=> $stable(stage_active));
endmodule

bind fetch_status_ctrl fsc_checker #(.NT(NT), .PC_W(PC_W)) u_chk (
    .clk            (clk),
    .rst            (rst),
    .thread_active  (thread_active),
    .stall_set      (stall_set),
    .stall_clr      (stall_clr),
    .commit_squash  (commit_squash),
    .commit_pc      (commit_pc),
    .rob_squashing  (rob_squashing),
    .decode_squash  (decode_squash),
    .cur_status     (cur_status),
    .next_status    (next_status),
    .status_changed (status_changed),
    .redirect_valid (redirect_valid),
    .redirect_pc    (redirect_pc),
    .drop_miss      (drop_miss),
    .stage_active   (stage_active)
);

// File: tb/sim_fetch_status_ctrl.sv
`timescale 1ns/1ps
module sim_fetch_status_ctrl;
    localparam int NT   = 4;
    localparam int PC_W = 32;

    logic clk = 1'b0;
    logic rst = 1'b1;
    always #2 clk = ~clk;

    // stimulus state
    bit              act [NT];
    bit              ctx;
    bit              sset[NT][4];
    bit              sclr[NT][4];
    bit              cmt [NT];
    bit              rob [NT];
    bit              dsq [NT];
    logic [31:0]     cpc [NT];
    logic [31:0]     dpc [NT];
    logic [3:0]      cur [NT];

    logic [NT-1:0]      thread_active_v, commit_squash_v, rob_squashing_v, decode_squash_v;
    logic [NT*4-1:0]    stall_set_v, stall_clr_v, cur_status_v;
    logic [NT*PC_W-1:0] commit_pc_v, decode_pc_v;

    logic [NT*4-1:0]    next_status;
    logic [NT-1:0]      status_changed, redirect_valid, drop_miss;
    logic [NT*PC_W-1:0] redirect_pc;
    logic               stage_active;

    always_comb begin
        for (int t = 0; t < NT; t++) begin
            thread_active_v[t] = act[t];
            commit_squash_v[t] = cmt[t];
            rob_squashing_v[t] = rob[t];
            decode_squash_v[t] = dsq[t];
            cur_status_v[t*4 +: 4] = cur[t];
            commit_pc_v[t*PC_W +: PC_W] = cpc[t];
            decode_pc_v[t*PC_W +: PC_W] = dpc[t];
            for (int s = 0; s < 4; s++) begin
                stall_set_v[t*4+s] = sset[t][s];
                stall_clr_v[t*4+s] = sclr[t][s];
            end
        end
    end

    fetch_status_ctrl #(.NT(NT), .PC_W(PC_W)) u0 (
        .clk(clk), .rst(rst),
        .thread_active(thread_active_v), .ctx_switch(ctx),
        .stall_set(stall_set_v), .stall_clr(stall_clr_v),
        .commit_squash(commit_squash_v), .commit_pc(commit_pc_v),
        .rob_squashing(rob_squashing_v),
        .decode_squash(decode_squash_v), .decode_pc(decode_pc_v),
        .cur_status(cur_status_v),
        .next_status(next_status), .status_changed(status_changed),
        .redirect_valid(redirect_valid), .redirect_pc(redirect_pc),
        .drop_miss(drop_miss), .stage_active(stage_active)
    );

    // reference model state
    bit          mbits[NT][4];
    bit          mact;
    bit          nbits[NT][4];
    bit          nact;
    logic [3:0]  enx [NT];
    bit          ech [NT];
    bit          erv [NT];
    logic [31:0] epc [NT];
    bit          edrop[NT];
    int          erule[NT];

    int checks = 0;
    int fails  = 0;
    bit done   = 0;

    task automatic chk(string tag, string what, int t, logic [31:0] got, logic [31:0] exp);
        checks++;
        if (got !== exp) begin
            fails++;
            $display("FAIL %s thread %0d %s: got %0h expected %0h", tag, t, what, got, exp);
        end
    endtask

    function automatic bit live_code(logic [3:0] s);
        return (s == 4'd0) || (s == 4'd2) || (s == 4'd8);
    endfunction

    task automatic model_eval();
        bit any_ch;
        bit any_live;
        any_ch = 0;
        any_live = 0;
        for (int t = 0; t < NT; t++) begin
            bit stalled;
            nbits[t] = mbits[t];
            enx[t] = cur[t]; ech[t] = 0; erv[t] = 0; epc[t] = '0; edrop[t] = 0;
            erule[t] = 9;
            if (!act[t]) begin
                erule[t] = 11;
            end else begin
                for (int s = 0; s < 4; s++) begin
                    if (sset[t][s])      nbits[t][s] = 1;
                    else if (sclr[t][s]) nbits[t][s] = 0;
                end
                stalled = ctx;
                for (int s = 0; s < 4; s++) stalled |= nbits[t][s];
                if (cmt[t]) begin
                    erule[t] = 4; enx[t] = 4'd2; ech[t] = 1; erv[t] = 1; epc[t] = cpc[t];
                    edrop[t] = (cur[t] == 4'd6);
                end else if (rob[t]) begin
                    erule[t] = 5; enx[t] = 4'd2; ech[t] = 1;
                end else if (dsq[t] && cur[t] != 4'd2) begin
                    erule[t] = 6; enx[t] = 4'd2; ech[t] = 1; erv[t] = 1; epc[t] = dpc[t];
                    edrop[t] = (cur[t] == 4'd6);
                end else if (stalled && cur[t] != 4'd6 && cur[t] != 4'd7) begin
                    erule[t] = 3; enx[t] = 4'd3; ech[t] = 1;
                end else if (cur[t] == 4'd3 || cur[t] == 4'd2) begin
                    erule[t] = 8; enx[t] = 4'd0; ech[t] = 1;
                end else if (stalled) begin
                    erule[t] = 7;
                end
                if (ech[t]) any_ch = 1;
                if (live_code(enx[t])) any_live = 1;
            end
        end
        nact = any_ch ? any_live : mact;
    endtask

    // inputs are already driven at a falling edge; settle, then compare
    task automatic eval_and_check();
        #1;
        model_eval();
        for (int t = 0; t < NT; t++) begin
            string tg;
            tg = $sformatf("R%0d", erule[t]);
            chk(tg, "next_status", t, 32'(next_status[t*4 +: 4]), 32'(enx[t]));
            chk(tg, "changed", t, 32'(status_changed[t]), 32'(ech[t]));
            chk(tg, "redirect_valid", t, 32'(redirect_valid[t]), 32'(erv[t]));
            if (erv[t])
                chk(tg, "redirect_pc", t, redirect_pc[t*PC_W +: PC_W], epc[t]);
            chk("R10", "drop_miss", t, 32'(drop_miss[t]), 32'(edrop[t]));
        end
    endtask

    task automatic advance();
        @(posedge clk);
        mbits = nbits;
        mact  = nact;
        @(negedge clk);
        chk("R12", "stage_active", 0, 32'(stage_active), 32'(mact));
    endtask

    task automatic quiet();
        ctx = 0;
        for (int t = 0; t < NT; t++) begin
            act[t] = 1; cmt[t] = 0; rob[t] = 0; dsq[t] = 0; cur[t] = 4'd0;
            cpc[t] = 32'h1000_0000 + 32'(t) * 32'h40;
            dpc[t] = 32'h2000_0000 + 32'(t) * 32'h80;
            for (int s = 0; s < 4; s++) begin sset[t][s] = 0; sclr[t][s] = 0; end
        end
    endtask

    task automatic rand_inputs();
        ctx = ($urandom % 16) == 0;
        for (int t = 0; t < NT; t++) begin
            act[t] = ($urandom % 8) != 0;
            cmt[t] = ($urandom % 8) == 0;
            rob[t] = ($urandom % 8) == 0;
            dsq[t] = ($urandom % 5) == 0;
            cur[t] = 4'($urandom % 9);
            cpc[t] = $urandom;
            dpc[t] = $urandom;
            for (int s = 0; s < 4; s++) begin
                sset[t][s] = ($urandom % 10) == 0;
                sclr[t][s] = mbits[t][s] && !sset[t][s] && (($urandom % 3) == 0);
            end
        end
    endtask

    initial begin : watchdog
        repeat (200000) @(posedge clk);
        if (!done) begin
            fails++;
            checks++;
            $display("FAIL all watchdog expired: got hang expected completion");
            $display("%0d/%0d checks passed", checks - fails, checks);
            $finish;
        end
    end

    initial begin : main
        int seed;
        seed = $urandom(32'h5EED_0042);
        quiet();
        for (int t = 0; t < NT; t++)
            for (int s = 0; s < 4; s++) mbits[t][s] = 0;
        mact = 1;
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst = 0;

        // R1: reset leaves the flag set and the stall bits clear
        chk("R1", "stage_active after reset", 0, 32'(stage_active), 32'd1);
        eval_and_check();
        chk("R1", "running stays running", 0, 32'(next_status[3:0]), 32'd0);
        chk("R1", "no change after reset", 0, 32'(status_changed[0]), 32'd0);
        advance();

        // R2 / R3: decode stall pulse blocks in the same cycle
        quiet(); sset[0][0] = 1;
        eval_and_check();
        chk("R3", "blocked on set pulse", 0, 32'(next_status[3:0]), 32'd3);
        advance();
        // R2: bit is sticky without a pulse; Blocked stays Blocked with changed high
        quiet(); cur[0] = 4'd3;
        eval_and_check();
        chk("R2", "sticky stall keeps blocked", 0, 32'(next_status[3:0]), 32'd3);
        chk("R3", "changed while re-blocked", 0, 32'(status_changed[0]), 32'd1);
        advance();
        // R7: cache-wait thread is not blocked by the held stall
        quiet(); cur[0] = 4'd6;
        eval_and_check();
        chk("R7", "cache wait shielded", 0, 32'(next_status[3:0]), 32'd6);
        chk("R7", "no change in cache wait", 0, 32'(status_changed[0]), 32'd0);
        advance();
        // R8: release the bit, Blocked returns to Running
        quiet(); cur[0] = 4'd3; sclr[0][0] = 1;
        eval_and_check();
        chk("R8", "blocked resumes", 0, 32'(next_status[3:0]), 32'd0);
        advance();

        // R6: decode squash while already squashing is ignored
        quiet(); cur[1] = 4'd2; dsq[1] = 1;
        eval_and_check();
        chk("R6", "no decode redirect while squashing", 1, 32'(redirect_valid[1]), 32'd0);
        chk("R6", "falls through to running", 1, 32'(next_status[7:4]), 32'd0);
        advance();
        // R6: decode squash from Running redirects
        quiet(); dsq[1] = 1;
        eval_and_check();
        chk("R6", "decode redirect pc", 1, redirect_pc[63:32], dpc[1]);
        advance();

        // R4 / R10: commit squash beats decode squash and drops the miss
        quiet(); cur[2] = 4'd6; cmt[2] = 1; dsq[2] = 1;
        eval_and_check();
        chk("R4", "commit pc wins", 2, redirect_pc[95:64], cpc[2]);
        chk("R10", "miss dropped", 2, 32'(drop_miss[2]), 32'd1);
        advance();

        // R5: reorder-buffer flush with decode squash gives no redirect
        quiet(); rob[3] = 1; dsq[3] = 1; cur[3] = 4'd6;
        eval_and_check();
        chk("R5", "flush status", 3, 32'(next_status[15:12]), 32'd2);
        chk("R5", "flush no redirect", 3, 32'(redirect_valid[3]), 32'd0);
        chk("R10", "flush keeps miss", 3, 32'(drop_miss[3]), 32'd0);
        advance();

        // R11: inactive thread ignores squash and stall pulses
        quiet(); act[2] = 0; cmt[2] = 1; sset[2][3] = 1; cur[2] = 4'd1;
        eval_and_check();
        chk("R11", "inactive unchanged", 2, 32'(status_changed[2]), 32'd0);
        advance();
        quiet(); cur[2] = 4'd0;
        eval_and_check();
        chk("R11", "stall bit not taken", 2, 32'(next_status[11:8]), 32'd0);
        advance();

        // R12: all threads blocked drops the flag; quiet running keeps it low
        quiet(); ctx = 1;
        for (int t = 0; t < NT; t++) cur[t] = 4'd3;
        eval_and_check();
        advance();
        chk("R12", "flag low when all blocked", 0, 32'(stage_active), 32'd0);
        quiet(); cur[0] = 4'd1;
        eval_and_check();
        advance();
        chk("R12", "flag holds without change", 0, 32'(stage_active), 32'd0);
        quiet(); cur[1] = 4'd3;
        eval_and_check();
        advance();
        chk("R12", "flag back on resume", 0, 32'(stage_active), 32'd1);

        // R9 and the mix: weighted random traffic against the model
        for (int i = 0; i < 3000; i++) begin
            rand_inputs();
            eval_and_check();
            advance();
        end

        done = 1;
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end
endmodule